// File: doc/BRIEF.md
# I2C Slave 32-bit Register Reader

This block is the read half of an I2C slave that hands out 32-bit registers one byte at a time. It watches SCL and SDA through a synchronizer clocked by a faster system clock and recognises START and STOP. It decodes the control byte and answers only its own 7-bit address when the direction bit requests a read. It then shifts out whole words, most significant byte first. SDA is driven open-drain through a single pull-low enable.

On the register side, an internal word address selects the register. At the start of every word the block raises a one-cycle snapshot request and captures the source's data in that same cycle. When all four bytes have gone out it raises a one-cycle commit pulse. If the word ends early, it raises an abort pulse instead. The address steps by one after each complete word, including the last word of a transfer, and it wraps to zero after its largest value. A master ACK after the fourth byte continues into the next word. A NACK ends the read.

Top module: `i2c_word_reader`

## Requirements
- R1: After reset, `sda_oe` is 0, `reg_addr` is 0 and none of `snap_req`, `word_done` or `word_abort` is asserted.
- R2: The block acknowledges a control byte (sent MSB first: seven address bits, then the direction bit) only when the address equals `DEV_ADDR` and the direction bit is 1, by pulling SDA low during the ninth clock. In every other case it leaves SDA released until the next START.
- R3: Each word goes out MSB first, bits 31..24 in the first byte. `sda_oe` = 1 sends a 0 bit and `sda_oe` = 0 sends a 1 bit.
- R4: `snap_req` is high for exactly one cycle at the start of each word, and the word sent is the value of `snap_data` in that cycle.
- R5: A master ACK after the fourth byte starts the next word, which is read from the incremented address.
- R6: After the fourth byte's acknowledge slot, `word_done` pulses once, and `reg_addr` is one higher in the following cycle. This holds whether the master answers that byte with ACK or NACK. `word_done` and `word_abort` never coincide.
- R7: `reg_addr` wraps from 2^ADDR_W-1 to 0 within a burst.
- R8: A master NACK on any of the first three bytes of a word pulses `word_abort`, leaves `reg_addr` unchanged and keeps SDA released until the next START.
- R9: A START or STOP in the middle of a word pulses `word_abort` with SDA released and `reg_addr` unchanged. A following START and read are served normally.
- R10: The block releases SDA during the master's acknowledge slot, and `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_addr | output | ADDR_W | Current word address |
| snap_req | output | 1 | One-cycle capture strobe for `snap_data` |
| snap_data | input | WORD_W | Register value for `reg_addr`, valid while `snap_req` is high |
| word_done | output | 1 | One-cycle pulse: full word sent |
| word_abort | output | 1 | One-cycle pulse: word cut short |

## Verification
The checks assume that the bus master moves SDA only while SCL is low, except when it makes a START or STOP. They also assume SCL stays low for more cycles than the synchronizer delay, so the block's drive change lands inside the low phase. The bench master waits several system cycles after each falling SCL edge before it moves SDA, and it holds each SCL phase far longer than the synchronizer. It places its deliberate mid-word START and STOP at bits where the block is sending a 1 and has therefore released the line. The register source returns a fixed function of the address, so every expected byte follows from the address the bench tracks itself.

// File: rtl/i2c_rd_pkg.sv
// Shared types for the I2C word reader.
package i2c_rd_pkg;
    // Read engine phases
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for START, bus ignored
        ST_ADDR,   // shifting in the control byte
        ST_AACK,   // driving the address acknowledge
        ST_TX,     // shifting out data bits
        ST_MACK,   // listening for master ACK/NACK
        ST_MHOLD   // master acked, waiting for SCL low to continue
    } rd_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes SCL and SDA into the system clock and derives SCL edges and
// START/STOP events. Assumes the system clock oversamples SCL well above the
// synchronizer depth.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;   // index 0: SCL, index 1: SDA

    logic [LINES-1:0] raw;
    logic [LINES-1:0] now_v;
    logic [LINES-1:0] old_v;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        // Metastability chain for one bus line, idles high
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], raw[g]};
        end
        assign now_v[g] = pipe[STAGES-1];
    end

    // One-cycle history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) old_v <= '1;
        else        old_v <= now_v;
    end

    assign sda_lvl   = now_v[1];
    assign scl_rise  =  now_v[0] & ~old_v[0];
    assign scl_fall  = ~now_v[0] &  old_v[0];
    assign start_det =  now_v[0] & old_v[0] &  old_v[1] & ~now_v[1];
    assign stop_det  =  now_v[0] & old_v[0] & ~old_v[1] &  now_v[1];
endmodule

// File: rtl/i2c_word_addr.sv
// Word address counter: steps by one on each completed word, wraps naturally.
module i2c_word_addr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ADDR_W-1:0] addr
);
    // Advance after every committed word
    always_ff @(posedge clk) begin
        if (!rst_n)    addr <= '0;
        else if (step) addr <= addr + 1'b1;
    end
endmodule

// File: rtl/i2c_word_fsm.sv
// Bit/byte engine: decodes the control byte, shifts words out MSB first,
// samples master acknowledges and reports snapshot, commit and abort.
// Assumes SCL edges and bus events arrive as one-cycle strobes, and that the
// register source answers snap_data combinationally in the snap_req cycle.
module i2c_word_fsm
    import i2c_rd_pkg::*;
#(
    parameter int         WORD_W   = 32,
    parameter logic [6:0] DEV_ADDR = 7'h2D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [WORD_W-1:0] snap_data,
    output logic              snap_req,
    output logic              sda_oe,
    output logic              word_done,
    output logic              word_abort
);
    localparam int            BYTES = WORD_W / 8;
    localparam int            BCW   = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [BCW-1:0] LAST = BCW'(BYTES - 1);
    localparam logic [7:0]    MATCH = {DEV_ADDR, 1'b1};

    rd_state_t         state;
    logic [3:0]        bit_cnt;
    logic [BCW-1:0]    byte_cnt;
    logic [WORD_W-1:0] shreg;
    logic [7:0]        rx;
    logic              word_open;
    logic              no_event;

    assign no_event = !start_det && !stop_det;

    // Capture strobe at the SCL fall that opens a new word
    assign snap_req = scl_fall && no_event &&
                      ((state == ST_AACK) ||
                       (state == ST_MHOLD && byte_cnt == LAST));

    // Main sequencer; bus events take priority over every phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            bit_cnt    <= '0;
            byte_cnt   <= '0;
            shreg      <= '0;
            rx         <= '0;
            sda_oe     <= 1'b0;
            word_open  <= 1'b0;
            word_done  <= 1'b0;
            word_abort <= 1'b0;
        end else begin
            word_done  <= 1'b0;
            word_abort <= 1'b0;
            if (start_det || stop_det) begin
                word_abort <= word_open;
                word_open  <= 1'b0;
                sda_oe     <= 1'b0;
                bit_cnt    <= '0;
                state      <= start_det ? ST_ADDR : ST_IDLE;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise && bit_cnt != 4'd8) begin
                            rx      <= {rx[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            if (rx == MATCH) begin
                                sda_oe <= 1'b1;
                                state  <= ST_AACK;
                            end else begin
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            shreg     <= snap_data;
                            sda_oe    <= ~snap_data[WORD_W-1];
                            word_open <= 1'b1;
                            bit_cnt   <= '0;
                            byte_cnt  <= '0;
                            state     <= ST_TX;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            shreg <= shreg << 1;
                            if (bit_cnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                state  <= ST_MACK;
                            end else begin
                                sda_oe  <= ~shreg[WORD_W-2];
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            if (byte_cnt == LAST) begin
                                word_done <= 1'b1;
                                word_open <= 1'b0;
                                state     <= sda_lvl ? ST_IDLE : ST_MHOLD;
                            end else if (!sda_lvl) begin
                                state <= ST_MHOLD;
                            end else begin
                                word_abort <= 1'b1;
                                word_open  <= 1'b0;
                                state      <= ST_IDLE;
                            end
                        end
                    end
                    ST_MHOLD: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            state   <= ST_TX;
                            if (byte_cnt == LAST) begin
                                shreg     <= snap_data;
                                sda_oe    <= ~snap_data[WORD_W-1];
                                word_open <= 1'b1;
                                byte_cnt  <= '0;
                            end else begin
                                sda_oe   <= ~shreg[WORD_W-1];
                                byte_cnt <= byte_cnt + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_word_reader.sv
// Top of the I2C slave word reader: bus synchronizer, read engine and word
// address counter. Assumes an external pull-up on SDA; sda_oe pulls it low.
module i2c_word_reader #(
    parameter int         WORD_W   = 32,
    parameter int         ADDR_W   = 8,
    parameter int         SYNC_N   = 2,
    parameter logic [6:0] DEV_ADDR = 7'h2D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              snap_req,
    input  logic [WORD_W-1:0] snap_data,
    output logic              word_done,
    output logic              word_abort
);
    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(.STAGES(SYNC_N)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_word_fsm #(.WORD_W(WORD_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_lvl    (sda_lvl),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .snap_data  (snap_data),
        .snap_req   (snap_req),
        .sda_oe     (sda_oe),
        .word_done  (word_done),
        .word_abort (word_abort)
    );

    i2c_word_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (word_done),
        .addr  (reg_addr)
    );
endmodule

// File: rtl/i2c_word_reader_chk.sv
// Property checker for the word reader, attached by bind below.
module i2c_word_reader_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_in,
    input logic              sda_oe,
    input logic              snap_req,
    input logic              word_done,
    input logic              word_abort,
    input logic [ADDR_W-1:0] reg_addr
);
    // R6
    commit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> reg_addr == ADDR_W'($past(reg_addr) + 1'b1));

    // R6
    done_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(word_done && word_abort));

    // R8
    abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_abort |=> reg_addr == $past(reg_addr));

    // R9
    abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_abort |-> !sda_oe);

    // R4
    snap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> !snap_req);

    // R10
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_in);
endmodule

bind i2c_word_reader i2c_word_reader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_in),
    .sda_oe     (sda_oe),
    .snap_req   (snap_req),
    .word_done  (word_done),
    .word_abort (word_abort),
    .reg_addr   (reg_addr)
);

// File: tb/tb_i2c_word_reader.sv
module tb_i2c_word_reader;
    localparam int         AW  = 4;
    localparam int         H   = 12;
    localparam logic [6:0] DEV = 7'h2D;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          m_scl = 1'b1;
    logic          m_sda = 1'b1;
    logic          bus_sda;
    logic          sda_oe, snap_req, word_done, word_abort;
    logic [AW-1:0] reg_addr;
    logic [31:0]   snap_data;

    int n_run = 0, n_fail = 0;
    int n_snap = 0, n_done = 0, n_abort = 0;
    int exp_addr = 0;
    exp_t       exp_q[$];
    logic [7:0] got_q[$];

    always #5 clk = ~clk;

    function automatic logic [31:0] regval(input logic [7:0] a);
        return {a, ~a, a ^ 8'hA5, {a[3:0], a[7:4]} ^ 8'h3C};
    endfunction

    assign bus_sda   = m_sda & ~sda_oe;
    assign snap_data = regval(8'(reg_addr));

    i2c_word_reader #(.ADDR_W(AW), .DEV_ADDR(DEV)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (m_scl),
        .sda_in     (bus_sda),
        .sda_oe     (sda_oe),
        .reg_addr   (reg_addr),
        .snap_req   (snap_req),
        .snap_data  (snap_data),
        .word_done  (word_done),
        .word_abort (word_abort)
    );

    // Pulse counters for the register-side strobes
    always @(posedge clk) begin
        if (rst_n) begin
            if (snap_req)   n_snap++;
            if (word_done)  n_done++;
            if (word_abort) n_abort++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One SCL period: drive SDA while low, sample in the high phase
    task automatic bit_cycle(input logic drv, output logic smp);
        tick(4);
        m_sda = drv;
        tick(H);
        m_scl = 1'b1;
        tick(H / 2);
        smp = bus_sda;
        tick(H / 2);
        m_scl = 1'b0;
    endtask

    task automatic i2c_start();
        tick(4);
        m_sda = 1'b1;
        tick(H);
        m_scl = 1'b1;
        tick(H);
        m_sda = 1'b0;
        tick(H);
        m_scl = 1'b0;
    endtask

    task automatic i2c_stop();
        tick(4);
        m_sda = 1'b0;
        tick(H);
        m_scl = 1'b1;
        tick(H);
        m_sda = 1'b1;
        tick(H);
    endtask

    task automatic send_ctrl(input logic [6:0] a, input logic rw, output logic acked);
        logic [7:0] b;
        logic       s;
        b = {a, rw};
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
        bit_cycle(1'b1, s);
        acked = !s;
    endtask

    // Eight released clocks, then the master's acknowledge bit
    task automatic read_raw(input logic ack, output logic [7:0] b);
        logic s;
        for (int i = 0; i < 8; i++) begin
            bit_cycle(1'b1, s);
            b = {b[6:0], s};
        end
        bit_cycle(!ack, s);
    endtask

    task automatic read_byte(input logic ack);
        logic [7:0] b;
        read_raw(ack, b);
        got_q.push_back(b);
    endtask

    task automatic expect_byte(input logic [31:0] w, input int idx, input string tag);
        exp_t e;
        e.val = w[31 - 8*idx -: 8];
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Driver: full read of n words from the tracked address
    task automatic run_read(input int n, input string tag);
        logic        acked;
        logic [31:0] w;
        i2c_start();
        send_ctrl(DEV, 1'b1, acked);
        check("R2 ack on match", acked, 1);
        for (int k = 0; k < n; k++) begin
            w = regval(8'(exp_addr));
            for (int j = 0; j < 4; j++) begin
                expect_byte(w, j, tag);
                read_byte(!(k == n - 1 && j == 3));
            end
            exp_addr = (exp_addr + 1) % (1 << AW);
        end
        i2c_stop();
    endtask

    // Monitor: pops received bytes and compares with the scoreboard
    initial begin
        forever begin
            logic [7:0] g;
            exp_t       e;
            wait (got_q.size() > 0);
            g = got_q.pop_front();
            if (exp_q.size() == 0) begin
                check("R3 unexpected byte", g, 0);
            end else begin
                e = exp_q.pop_front();
                check(e.tag, g, e.val);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic       acked;
        logic [7:0] b;
        int         d0, a0;
        tick(5);
        // R1 reset state
        check("R1 sda_oe", sda_oe, 0);
        check("R1 reg_addr", reg_addr, 0);
        check("R1 strobes", snap_req | word_done | word_abort, 0);
        rst_n = 1'b1;
        tick(5);

        // R2 wrong address: no ack, line stays released
        i2c_start();
        send_ctrl(DEV ^ 7'h01, 1'b1, acked);
        check("R2 no ack on mismatch", acked, 0);
        read_raw(1'b1, b);
        check("R2 released after mismatch", b, 8'hFF);
        i2c_stop();
        // R2 write direction: no ack
        i2c_start();
        send_ctrl(DEV, 1'b0, acked);
        check("R2 no ack on write", acked, 0);
        i2c_stop();
        check("R2 no snapshot", n_snap, 0);

        // R3/R4/R6 single read at 0
        run_read(1, "R3 single byte");
        tick(4);
        check("R6 addr after single", reg_addr, 1);
        check("R6 commit count", n_done, 1);
        check("R4 snapshot count", n_snap, 1);

        // R5 burst of three
        run_read(3, "R5 burst byte");
        tick(4);
        check("R5 addr after burst", reg_addr, 4);
        check("R5 commit count", n_done, 4);
        check("R4 snapshot per word", n_snap, 4);

        // R8 NACK on second byte
        d0 = n_done;
        i2c_start();
        send_ctrl(DEV, 1'b1, acked);
        expect_byte(regval(8'd4), 0, "R8 byte0");
        read_byte(1'b1);
        expect_byte(regval(8'd4), 1, "R8 byte1");
        read_byte(1'b0);
        read_raw(1'b1, b);
        check("R8 released after nack", b, 8'hFF);
        i2c_stop();
        tick(4);
        check("R8 abort count", n_abort, 1);
        check("R8 no commit", n_done, d0);
        check("R8 addr kept", reg_addr, 4);

        // R9 STOP in the middle of a word (next bit is 1)
        i2c_start();
        send_ctrl(DEV, 1'b1, acked);
        expect_byte(regval(8'd4), 0, "R9 byte0");
        read_byte(1'b1);
        expect_byte(regval(8'd4), 1, "R9 byte1");
        read_byte(1'b1);
        i2c_stop();
        tick(4);
        check("R9 sda released on stop", sda_oe, 0);
        check("R9 abort on stop", n_abort, 2);
        check("R9 addr kept", reg_addr, 4);

        // R9 repeated START in the middle of a word, then a normal read
        i2c_start();
        send_ctrl(DEV, 1'b1, acked);
        expect_byte(regval(8'd4), 0, "R9 byte0 again");
        read_byte(1'b1);
        a0 = n_abort;
        run_read(1, "R9 read after restart");
        tick(4);
        check("R9 abort on start", n_abort, a0 + 1);
        check("R9 addr after restart read", reg_addr, 5);

        // R7 burst across the wrap point
        run_read(13, "R7 wrap byte");
        tick(4);
        check("R7 addr after wrap", reg_addr, 2);
        check("R10 idle release", sda_oe, 0);

        wait (got_q.size() == 0);
        tick(2);
        check("R3 scoreboard drained", exp_q.size(), 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule